// File: doc/BRIEF.md
# Clock-Stop Serial Master with Programmable Clock Divider

This block is a serial master that runs a single SPI transfer and then stops its clock. A divider turns an input tick stream into the serial clock. The ticks come either from every cycle of the system clock or from the rising edges of an external clock, which is synchronized into the system domain first. The serial clock idles high. When the clock is stopped, the data-out pin is released by dropping its output enable.

A transfer begins with a one-cycle `start` request. The block then latches the divider value, the word length, the tick source and the transmit word, and pulls the active-low select. It waits one clock-high width and then produces one falling edge for each bit. The word goes out most significant bit first, and new data is driven just after each falling edge. Each input bit is captured on the following rising edge. After the last rising edge the output enable drops one high width later. The select returns high one full serial period after that same edge. In the cycle the select rises, `done` pulses and the received word is presented.

Top module: `spi_stop_master`

## Requirements
- R1: In reset and whenever no transfer is active: `spi_sclk`=1, `spi_ss_n`=1, `spi_sdo_oe`=0, `busy`=0 and `done`=0.
- R2: With effective divider value g, the serial period is g+1 ticks. For even g the low width is g/2 ticks and the high width is g/2+1 ticks. For odd g both widths are (g+1)/2 ticks.
- R3: A divider value of 0 is handled exactly as a divider value of 1.
- R4: With `clk_sel`=1, one tick is counted for each rising edge of `ext_clk`. With `clk_sel`=0, one tick is counted for each system clock cycle.
- R5: A start accepted at clock edge E0 drives `spi_ss_n` low after E0. The first falling serial clock edge follows one high width later.
- R6: Bits n-1 down to 0 of `tx_word` appear on `spi_sdo`, one per falling edge, with `spi_sdo_oe`=1. Exactly n clock pulses are produced.
- R7: `spi_sdi` is sampled on each rising serial clock edge. `rx_word` holds the n received bits in bits n-1..0, with the first bit at bit n-1 and the upper bits cleared.
- R8: `spi_sdo_oe` drops one high width after the last rising edge. `spi_ss_n` rises one full period (g+1 ticks) after that edge.
- R9: `done` is high for exactly one cycle, in the cycle `spi_ss_n` returns high. `rx_word` is updated at that same edge.
- R10: A `start` while `busy`=1 is ignored. The running transfer keeps its latched word and settings, and no second transfer follows.
- R11: The word length n is `word_len` clamped into 8..32: values below 8 give 8 and values above 32 give 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, accepted only when idle |
| clk_sel | input | 1 | Tick source: 0 system clock, 1 external clock |
| ext_clk | input | 1 | External divider input clock |
| gdv | input | GDV_W | Divider value g |
| word_len | input | LEN_W | Requested bits per word |
| tx_word | input | MAXW | Word to send, right-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | MAXW | Last received word, right-aligned |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_ss_n | output | 1 | Active-low slave select |
| spi_sdo | output | 1 | Serial data out, 0 when not enabled |
| spi_sdo_oe | output | 1 | Output enable of serial data out; 0 means high impedance |
| spi_sdi | input | 1 | Serial data in |

## Verification
All timing is counted from E0, the clock edge that accepts the start. In system-tick mode the following results are due at fixed edges after E0, with H the high width, T the period and n the word length:
- select low: edge E0
- falling edge j: E(H+(j-1)T)
- rising edge j: E(jT)
- output enable dropping: E(nT+H)
- select high, `done` and `rx_word`: E((n+1)T)

The bench samples on the falling clock edge and counts edges from E0, so each observation sits half a cycle after the register that produced it. It compares the edge index at which each pin change was seen against these formulas. In external-tick mode, where the start phase depends on where the ext_clk edges happen to fall relative to E0, it checks instead the fixed intervals of six system cycles per tick between edges.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH,
    PH_TAILH,
    PH_TAILL
  } phase_e;

  // divider value actually used: zero would need half-tick widths
  function automatic int unsigned eff_div(int unsigned g);
    return (g == 0) ? 1 : g;
  endfunction

  // serial clock high width in ticks
  function automatic int unsigned high_ticks(int unsigned g);
    int unsigned e;
    e = eff_div(g);
    if ((e % 2) == 0) return e / 2 + 1;
    return (e + 1) / 2;
  endfunction

  // serial clock low width in ticks
  function automatic int unsigned low_ticks(int unsigned g);
    int unsigned e;
    e = eff_div(g);
    if ((e % 2) == 0) return e / 2;
    return (e + 1) / 2;
  endfunction

  function automatic int unsigned clamp_len(int unsigned l, int unsigned lo,
                                            int unsigned hi);
    if (l < lo) return lo;
    if (l > hi) return hi;
    return l;
  endfunction

endpackage

// File: rtl/ssm_tick_gen.sv
module ssm_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic ext_clk,
  output logic tick
);

  // bit 0 is the newest sample; the extra top bit feeds edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick     = use_ext ? ext_rise : 1'b1;

endmodule

// File: rtl/ssm_phase_seq.sv
module ssm_phase_seq
  import ssm_pkg::*;
#(
  parameter int GDV_W = 8,
  parameter int LEN_W = 6,
  parameter int MINW  = 8,
  parameter int MAXW  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [GDV_W-1:0] gdv,
  input  logic [LEN_W-1:0] word_len,
  output logic             busy,
  output logic             accept_ev,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             end_ev,
  output logic             sclk,
  output logic             frame,
  output logic             oe,
  output logic [GDV_W-1:0] g_eff
);

  localparam int CW = GDV_W;

  phase_e           ph_q;
  logic [CW-1:0]    cnt_q;
  logic [GDV_W-1:0] g_q;
  logic [LEN_W-1:0] left_q;
  logic             sclk_q, frame_q, oe_q;
  logic             phase_end, last_bit;
  logic [CW-1:0]    hi_load, lo_load, lead_load;

  always_comb begin
    hi_load   = CW'(high_ticks(32'(g_q)) - 1);
    lo_load   = CW'(low_ticks(32'(g_q)) - 1);
    lead_load = CW'(high_ticks(32'(gdv)) - 1);
  end

  assign busy      = (ph_q != PH_IDLE);
  assign accept_ev = start && (ph_q == PH_IDLE);
  assign phase_end = busy && tick && (cnt_q == '0);
  assign fall_ev   = phase_end && ((ph_q == PH_LEAD) || (ph_q == PH_HIGH));
  assign rise_ev   = phase_end && (ph_q == PH_LOW);
  assign end_ev    = phase_end && (ph_q == PH_TAILL);
  assign last_bit  = (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      g_q     <= GDV_W'(1);
      left_q  <= '0;
      sclk_q  <= 1'b1;
      frame_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (accept_ev) begin
      ph_q    <= PH_LEAD;
      cnt_q   <= lead_load;
      g_q     <= GDV_W'(eff_div(32'(gdv)));
      left_q  <= LEN_W'(clamp_len(32'(word_len), MINW, MAXW));
      frame_q <= 1'b1;
    end else if (busy && tick) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        case (ph_q)
          PH_LEAD, PH_HIGH: begin
            ph_q   <= PH_LOW;
            cnt_q  <= lo_load;
            sclk_q <= 1'b0;
            oe_q   <= 1'b1;
          end
          PH_LOW: begin
            ph_q   <= last_bit ? PH_TAILH : PH_HIGH;
            cnt_q  <= hi_load;
            sclk_q <= 1'b1;
            left_q <= left_q - LEN_W'(1);
          end
          PH_TAILH: begin
            ph_q  <= PH_TAILL;
            cnt_q <= lo_load;
            oe_q  <= 1'b0;
          end
          PH_TAILL: begin
            ph_q    <= PH_IDLE;
            frame_q <= 1'b0;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  assign sclk  = sclk_q;
  assign frame = frame_q;
  assign oe    = oe_q;
  assign g_eff = g_q;

endmodule

// File: rtl/ssm_shift_unit.sv
module ssm_shift_unit
  import ssm_pkg::*;
#(
  parameter int MAXW  = 32,
  parameter int MINW  = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             fall,
  input  logic             rise,
  input  logic [MAXW-1:0]  tx_word,
  input  logic [LEN_W-1:0] word_len,
  input  logic             sdi,
  output logic             sdo_bit,
  output logic [MAXW-1:0]  rx_shift
);

  logic [LEN_W-1:0] n_w;
  logic [MAXW-1:0]  tx_q, rx_q;
  logic             sdo_q;

  assign n_w = LEN_W'(clamp_len(32'(word_len), MINW, MAXW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      sdo_q <= 1'b0;
    end else if (load) begin
      // left-justify so the first bit to send sits at the top
      tx_q <= tx_word << (LEN_W'(MAXW) - n_w);
      rx_q <= '0;
    end else begin
      if (fall) begin
        sdo_q <= tx_q[MAXW-1];
        tx_q  <= {tx_q[MAXW-2:0], 1'b0};
      end
      if (rise) rx_q <= {rx_q[MAXW-2:0], sdi};
    end
  end

  assign sdo_bit  = sdo_q;
  assign rx_shift = rx_q;

endmodule

// File: rtl/spi_stop_master.sv
module spi_stop_master #(
  parameter int GDV_W       = 8,
  parameter int MAXW        = 32,
  parameter int MINW        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clk_sel,
  input  logic             ext_clk,
  input  logic [GDV_W-1:0] gdv,
  input  logic [LEN_W-1:0] word_len,
  input  logic [MAXW-1:0]  tx_word,
  output logic             busy,
  output logic             done,
  output logic [MAXW-1:0]  rx_word,
  output logic             spi_sclk,
  output logic             spi_ss_n,
  output logic             spi_sdo,
  output logic             spi_sdo_oe,
  input  logic             spi_sdi
);

  logic             tick, sel_q;
  logic             accept_ev, fall_ev, rise_ev, end_ev;
  logic             frame, oe, sdo_bit;
  logic [GDV_W-1:0] g_eff;
  logic [MAXW-1:0]  rx_shift, rx_word_q;
  logic             done_q;

  ssm_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) tick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .use_ext (sel_q),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  ssm_phase_seq #(.GDV_W(GDV_W), .LEN_W(LEN_W), .MINW(MINW), .MAXW(MAXW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (tick),
    .gdv       (gdv),
    .word_len  (word_len),
    .busy      (busy),
    .accept_ev (accept_ev),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .end_ev    (end_ev),
    .sclk      (spi_sclk),
    .frame     (frame),
    .oe        (oe),
    .g_eff     (g_eff)
  );

  ssm_shift_unit #(.MAXW(MAXW), .MINW(MINW), .LEN_W(LEN_W)) shf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_ev),
    .fall     (fall_ev),
    .rise     (rise_ev),
    .tx_word  (tx_word),
    .word_len (word_len),
    .sdi      (spi_sdi),
    .sdo_bit  (sdo_bit),
    .rx_shift (rx_shift)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      done_q    <= 1'b0;
      rx_word_q <= '0;
    end else begin
      if (accept_ev) sel_q <= clk_sel;
      done_q <= end_ev;
      if (end_ev) rx_word_q <= rx_shift;
    end
  end

  assign spi_ss_n   = ~frame;
  assign spi_sdo_oe = oe;
  assign spi_sdo    = oe & sdo_bit;
  assign done       = done_q;
  assign rx_word    = rx_word_q;

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker
  import ssm_pkg::*;
#(
  parameter int GDV_W = 8,
  parameter int MAXW  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic             ss_n,
  input logic             oe,
  input logic             use_ext,
  input logic             fall_ev,
  input logic             rise_ev,
  input logic [GDV_W-1:0] g_eff
);

  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= 0;
    else if (!sclk) low_cnt <= low_cnt + 1;
    else            low_cnt <= 0;
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && ss_n && !oe)); // R1

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !use_ext) |-> (low_cnt == low_ticks(32'(g_eff)))); // R2

  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> !ss_n); // R5

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_ev, rise_ev})); // R6

  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !ss_n); // R8

  AST_DONE_AT_SS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> done); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(g_eff)); // R10

endmodule

bind spi_stop_master ssm_checker #(.GDV_W(GDV_W), .MAXW(MAXW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .sclk    (spi_sclk),
  .ss_n    (spi_ss_n),
  .oe      (spi_sdo_oe),
  .use_ext (sel_q),
  .fall_ev (fall_ev),
  .rise_ev (rise_ev),
  .g_eff   (g_eff)
);

// File: tb/spi_stop_master_tb_top.sv
`timescale 1ns/1ps
module spi_stop_master_tb_top;

  localparam int GW = 8;
  localparam int MW = 32;
  localparam int LW = 6;
  localparam int NV = 7;

  // vector table: divider, requested length, transmit word, slave reply
  localparam int          V_G  [NV] = '{4, 5, 1, 2, 0, 7, 3};
  localparam int          V_L  [NV] = '{8, 8, 16, 32, 12, 5, 40};
  localparam logic [31:0] V_TX [NV] = '{32'h000000A5, 32'h0000003C, 32'h0000BEEF,
                                        32'hDEADBEEF, 32'h00000ABC, 32'h00000081,
                                        32'hCAFEF00D};
  localparam logic [31:0] V_SW [NV] = '{32'h0000005A, 32'h000000C3, 32'h00001234,
                                        32'h89ABCDEF, 32'h00000F0F, 32'h0000007E,
                                        32'h13579BDF};

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, clk_sel = 1'b0;
  logic          ext_clk = 1'b0, spi_sdi = 1'b0;
  logic [GW-1:0] gdv = '0;
  logic [LW-1:0] word_len = '0;
  logic [MW-1:0] tx_word = '0;
  wire           busy, done, spi_sclk, spi_ss_n, spi_sdo, spi_sdo_oe;
  wire  [MW-1:0] rx_word;

  int n_chk = 0;
  int n_bad = 0;
  int ediv  = 0;

  always #2 clk = ~clk;

  // external clock: period of six system cycles
  always @(negedge clk) begin
    if (ediv == 2) begin
      ediv    <= 0;
      ext_clk <= ~ext_clk;
    end else begin
      ediv <= ediv + 1;
    end
  end

  spi_stop_master dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .clk_sel    (clk_sel),
    .ext_clk    (ext_clk),
    .gdv        (gdv),
    .word_len   (word_len),
    .tx_word    (tx_word),
    .busy       (busy),
    .done       (done),
    .rx_word    (rx_word),
    .spi_sclk   (spi_sclk),
    .spi_ss_n   (spi_ss_n),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .spi_sdi    (spi_sdi)
  );

  task automatic chk_eq(input string req, input string what,
                        input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic idle_pins(input string req);
    chk_eq(req, "sclk idle", spi_sclk, 1);
    chk_eq(req, "ss_n idle", spi_ss_n, 1);
    chk_eq(req, "oe idle", spi_sdo_oe, 0);
    chk_eq(req, "busy idle", busy, 0);
  endtask

  task automatic run_xfer(input int g_in, input int l_in, input logic [31:0] tx,
                          input logic [31:0] sw, input bit ext, input bit poke,
                          input string ttag);
    int g, n, per, lo, hi, m, cyc, falls, rises, last_fall, last_rise;
    int oe_off, ss_hi, done_at, done_n;
    bit tbad, prev_s, prev_oe;
    logic [31:0] mo, mask;
    g = (g_in == 0) ? 1 : g_in;
    n = (l_in < 8) ? 8 : ((l_in > 32) ? 32 : l_in);
    per = g + 1;
    lo = g / 2 + g % 2;
    hi = per - lo;
    m = ext ? 6 : 1;
    mask = (n == 32) ? 32'hFFFFFFFF : ((32'd1 << n) - 32'd1);
    cyc = 0; falls = 0; rises = 0; last_fall = -1; last_rise = -1;
    oe_off = -1; ss_hi = -1; done_at = -1; done_n = 0;
    tbad = 1'b0; prev_s = 1'b1; prev_oe = 1'b0; mo = '0;

    @(negedge clk);
    gdv = GW'(g_in); word_len = LW'(l_in); tx_word = tx; clk_sel = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_eq("R5", "ss_n low after accept", spi_ss_n, 0);

    while (ss_hi < 0 && cyc < 20000) begin
      if (prev_s && !spi_sclk) begin
        if (!ext) begin
          if (cyc != hi + falls * per) tbad = 1'b1;
        end else if (falls > 0 && cyc - last_fall != m * per) tbad = 1'b1;
        if (falls < n) spi_sdi = sw[n - 1 - falls];
        falls++;
        last_fall = cyc;
      end
      if (!prev_s && spi_sclk) begin
        if (!ext) begin
          if (cyc != (rises + 1) * per) tbad = 1'b1;
        end else if (cyc - last_fall != m * lo) tbad = 1'b1;
        if (!spi_sdo_oe) tbad = 1'b1;
        mo = {mo[30:0], spi_sdo};
        rises++;
        last_rise = cyc;
      end
      if (prev_oe && !spi_sdo_oe && oe_off < 0) oe_off = cyc;
      if (spi_ss_n) ss_hi = cyc;
      if (done) begin
        done_n++;
        done_at = cyc;
      end
      prev_s = spi_sclk;
      prev_oe = spi_sdo_oe;
      if (poke && cyc == 2 * per * m) begin
        start = 1'b1;
        tx_word = ~tx;
      end
      if (poke && cyc == 2 * per * m + 1) start = 1'b0;
      if (ss_hi < 0) begin
        @(negedge clk);
        cyc++;
      end
    end

    chk_eq(ttag, "edge timing errors", tbad, 0);
    chk_eq("R6", "falling edge count", falls, n);
    chk_eq("R6", "rising edge count", rises, n);
    chk_eq("R6", "word seen on sdo", mo, tx & mask);
    if (!ext) begin
      chk_eq("R8", "oe drop cycle", oe_off, n * per + hi);
      chk_eq("R8", "ss_n rise cycle", ss_hi, (n + 1) * per);
    end else begin
      chk_eq("R8", "oe drop after last rise", oe_off - last_rise, m * hi);
      chk_eq("R8", "ss_n rise after last rise", ss_hi - last_rise, m * per);
    end
    chk_eq("R9", "done with ss_n rise", done_at, ss_hi);
    chk_eq("R7", "received word", rx_word, sw & mask);
    @(negedge clk);
    if (done) done_n++;
    chk_eq("R9", "done pulse count", done_n, 1);
    if (poke) chk_eq("R10", "no restart after ignored start", busy, 0);
    idle_pins("R1");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_pins("R1");
    chk_eq("R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_pins("R1");
    chk_eq("R1", "done after reset", done, 0);

    for (int i = 0; i < NV; i++) begin
      // entry 4 has divider 0 (R3); entries 5 and 6 clamp the length (R11)
      run_xfer(V_G[i], V_L[i], V_TX[i], V_SW[i], 1'b0, 1'b0,
               (V_G[i] == 0) ? "R3" : ((V_L[i] < 8 || V_L[i] > 32) ? "R11" : "R2"));
    end

    // external tick source
    run_xfer(2, 8, 32'h000000C9, 32'h00000036, 1'b1, 1'b0, "R4");
    run_xfer(5, 10, 32'h00000213, 32'h0000019A, 1'b1, 1'b0, "R4");
    // start while busy must be ignored
    run_xfer(3, 10, 32'h000002B7, 32'h00000155, 1'b0, 1'b1, "R10");
    // largest divider value, odd
    run_xfer(255, 8, 32'h00000096, 32'h00000069, 1'b0, 1'b0, "R2");
    // largest even divider value
    run_xfer(254, 8, 32'h000000F0, 32'h0000000F, 1'b0, 1'b0, "R2");

    summary();
    $finish;
  end

endmodule